// File: doc/BRIEF.md
# Dual-Port Start Scheduler with Read-After-Write Forwarding

This block decides, on every rising edge of the true input clock, whether a read burst, a write burst or nothing begins on a memory array that a separate read port and write port share. It runs on a clock at twice the input clock rate, so that every half-cycle of the input clock is one edge. A phase register marks which edges are true-clock rises, and both request inputs are looked at only on those edges. When both ports request at once, the result depends on what began on the previous true-clock rise. A port that began a burst on the previous rise cannot begin another one, so a steady pair of requests gives reads and writes in turn, and the first of them is a read.

A write burst brings in four 18-bit beats, one on each of the four edges after its start. Each beat carries two byte enables, and each enable covers 9 bits. The burst is committed to the array on the edge of its last beat. A read takes a snapshot of its word at its start edge. Any beats of a still-open write to the same address are merged into that snapshot, both those already buffered and those that arrive later, so the read always returns the newest data. The read data leaves as four beats. An early-valid flag runs half a cycle ahead of the beats, and a valid flag marks the beats themselves.

The read-data output has no ready input and cannot be back-pressured. A burst always takes four consecutive edges, and the receiver must accept every beat while `rq_valid` is high. Requests that lose arbitration or arrive too soon are dropped, not queued.

Top module: `qrw_port_sched`

## Requirements
- R1: `rd_req`, `wr_req`, `rd_addr` and `wr_addr` are sampled only on true-clock edges, which are the edges where `k_next` was 1. Their values on the other edges have no effect. The grant outputs change only on true-clock edges.
- R2: After each true-clock edge, exactly one of `gnt_rd`, `gnt_wr`, `gnt_idle` is 1, so at most one burst begins on any true-clock rise.
- R3: When both ports request, the read wins if the previous grant was idle or write, and the write wins if the previous grant was read.
- R4: A read request right after a read grant, or a write request right after a write grant, is dropped. The grant is idle unless the other port wins, and a dropped write changes no stored data.
- R5: Holding both requests high from an idle grant gives grants of read, write, read, write and so on, starting with read.
- R6: A read returns, for every byte, the value of the latest write to that address granted before the read. This includes a write granted on the previous true-clock rise whose beats are still arriving.
- R7: Write beat k (k = 0..3) is taken on the k+1-th edge after the write grant edge. Bit j of `wd_be` enables bits [9j+8:9j] of that beat. A byte whose enable is 0 keeps its old value. Beat and enable values on any other edge are ignored.
- R8: For a read granted on edge n, read beat k appears on `rq_data` after edge n+5+k, with `rq_valid` high. Beat k holds bits [18k+17:18k] of the stored word. `rq_valid` is 0 after every other edge.
- R9: `rq_early` is high after edges n+4 to n+7 of each read burst, which is half a clock cycle before each beat, and is low otherwise.
- R10: After reset, `gnt_idle` is 1, `gnt_rd`, `gnt_wr`, `rq_valid` and `rq_early` are 0, and `k_next` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the input clock rate; each edge is one half-cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read port request, sampled on true-clock edges |
| rd_addr | input | AW (4) | Read address, sampled with rd_req |
| wr_req | input | 1 | Write port request, sampled on true-clock edges |
| wr_addr | input | AW (4) | Write address, sampled with wr_req |
| wd_beat | input | 18 | Write data beat |
| wd_be | input | 2 | Byte enables for wd_beat, bit j for bits 9j+8..9j |
| k_next | output | 1 | 1 when the coming edge is a true-clock edge |
| gnt_rd | output | 1 | Read burst began on the last true-clock edge |
| gnt_wr | output | 1 | Write burst began on the last true-clock edge |
| gnt_idle | output | 1 | Nothing began on the last true-clock edge |
| rq_early | output | 1 | Early valid, half a cycle ahead of each read beat |
| rq_valid | output | 1 | rq_data carries a read beat |
| rq_data | output | 18 | Read data beat |

## Verification
The hard collision is a read start that falls on an edge where an open write to the same address is either committing its last beat or still receiving beats. Then the array read, the buffered beats and the live beat must all be merged in the same cycle. The bench provokes this by holding both requests high on a small address set, which forces read/write alternation, and by aiming random traffic at four addresses. Every returned beat is compared with a byte-level reference that applies each write in full at the moment it is granted. Arbitration and beat timing are judged on every edge against the bench's own grant model.

// File: rtl/qrw_pkg.sv
package qrw_pkg;
  localparam int BEAT_W  = 18;
  localparam int BYTE_W  = 9;
  localparam int BEATS   = 4;
  localparam int BE_W    = BEAT_W / BYTE_W;
  localparam int WORD_W  = BEAT_W * BEATS;
  localparam int MASK_W  = BE_W * BEATS;
  localparam int CNT_W   = $clog2(BEATS);

  // Replace the enabled 9-bit bytes of old_v with those of new_v.
  function automatic logic [BEAT_W-1:0] merge_beat(input logic [BEAT_W-1:0] old_v,
                                                   input logic [BEAT_W-1:0] new_v,
                                                   input logic [BE_W-1:0]   be);
    logic [BEAT_W-1:0] r;
    r = old_v;
    for (int j = 0; j < BE_W; j++)
      if (be[j]) r[j*BYTE_W +: BYTE_W] = new_v[j*BYTE_W +: BYTE_W];
    return r;
  endfunction
endpackage

// File: rtl/qrw_arbiter.sv
module qrw_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic k_edge,
  input  logic rd_req,
  input  logic wr_req,
  output logic rd_start,
  output logic wr_start,
  output logic gnt_rd,
  output logic gnt_wr,
  output logic gnt_idle
);
  logic rd_ok, wr_ok;

  // The held grant is the previous rise's action; a port cannot start twice in a row.
  assign rd_ok    = rd_req & ~gnt_rd;
  assign wr_ok    = wr_req & ~gnt_wr;
  assign rd_start = k_edge & rd_ok;
  assign wr_start = k_edge & wr_ok & ~rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_rd   <= 1'b0;
      gnt_wr   <= 1'b0;
      gnt_idle <= 1'b1;
    end else if (k_edge) begin
      gnt_rd   <= rd_start;
      gnt_wr   <= wr_start;
      gnt_idle <= ~(rd_start | wr_start);
    end
  end
endmodule

// File: rtl/qrw_array.sv
module qrw_array
  import qrw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [MASK_W-1:0] wmask,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < MASK_W; b++)
        if (wmask[b]) mem[waddr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qrw_wr_buffer.sv
module qrw_wr_buffer
  import qrw_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic [BEAT_W-1:0] beat,
  input  logic [BE_W-1:0]   be,
  output logic              active,
  output logic [AW-1:0]     addr,
  output logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] bufw,
  output logic [MASK_W-1:0] bufm,
  output logic              cm_en,
  output logic [WORD_W-1:0] cm_data,
  output logic [MASK_W-1:0] cm_mask
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      addr   <= '0;
      cnt    <= '0;
      bufw   <= '0;
      bufm   <= '0;
    end else begin
      if (active) begin
        bufw[int'(cnt)*BEAT_W +: BEAT_W] <= beat;
        bufm[int'(cnt)*BE_W +: BE_W]     <= be;
        cnt <= cnt + 1'b1;
        if (cnt == LAST) active <= 1'b0;
      end
      // A new burst may open on the edge that closes the previous one.
      if (start) begin
        active <= 1'b1;
        addr   <= start_addr;
        cnt    <= '0;
      end
    end
  end

  // Commit on the last beat: earlier beats from the buffer, the last one live.
  always_comb begin
    cm_en   = active && (cnt == LAST);
    cm_data = bufw;
    cm_mask = bufm;
    cm_data[(BEATS-1)*BEAT_W +: BEAT_W] = beat;
    cm_mask[(BEATS-1)*BE_W +: BE_W]     = be;
  end
endmodule

// File: rtl/qrw_rd_pipe.sv
module qrw_rd_pipe
  import qrw_pkg::*;
#(
  parameter int AW       = 4,
  parameter int LAT_HALF = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_start,
  input  logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              pend_active,
  input  logic [AW-1:0]     pend_addr,
  input  logic [CNT_W-1:0]  pend_cnt,
  input  logic [WORD_W-1:0] pend_w,
  input  logic [MASK_W-1:0] pend_m,
  input  logic [BEAT_W-1:0] live_beat,
  input  logic [BE_W-1:0]   live_be,
  output logic              rq_early,
  output logic              rq_valid,
  output logic [BEAT_W-1:0] rq_data
);
  localparam int PIPE = LAT_HALF + BEATS - 1;
  localparam int LOAD = LAT_HALF - 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [PIPE-1:0]   tok;
  logic [WORD_W-1:0] rd_word, cap_word, fwd_word, obuf;
  logic [BEAT_W-1:0] nxt_data;
  logic              fw_q, hit;

  assign hit = pend_active && (pend_addr == rd_addr);

  // Snapshot at the start edge: array, buffered beats, and the beat arriving now.
  always_comb begin
    cap_word = mem_rdata;
    for (int k = 0; k < BEATS; k++) begin
      if (hit && (CNT_W'(k) < pend_cnt))
        cap_word[k*BEAT_W +: BEAT_W] = merge_beat(cap_word[k*BEAT_W +: BEAT_W],
                                                  pend_w[k*BEAT_W +: BEAT_W],
                                                  pend_m[k*BE_W +: BE_W]);
      else if (hit && (CNT_W'(k) == pend_cnt))
        cap_word[k*BEAT_W +: BEAT_W] = merge_beat(cap_word[k*BEAT_W +: BEAT_W],
                                                  live_beat, live_be);
    end
  end

  // Later beats of the same open write keep flowing into the snapshot.
  always_comb begin
    fwd_word = rd_word;
    fwd_word[int'(pend_cnt)*BEAT_W +: BEAT_W] =
      merge_beat(rd_word[int'(pend_cnt)*BEAT_W +: BEAT_W], live_beat, live_be);
  end

  always_comb begin
    nxt_data = rq_data;
    for (int k = 0; k < BEATS; k++)
      if (tok[LAT_HALF-1+k]) nxt_data = obuf[k*BEAT_W +: BEAT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok      <= '0;
      rd_word  <= '0;
      fw_q     <= 1'b0;
      obuf     <= '0;
      rq_early <= 1'b0;
      rq_valid <= 1'b0;
      rq_data  <= '0;
    end else begin
      tok <= {tok[PIPE-2:0], rd_start};
      if (rd_start) begin
        rd_word <= cap_word;
        fw_q    <= hit && (pend_cnt != LAST);
      end else if (fw_q) begin
        rd_word <= fwd_word;
        fw_q    <= pend_active && (pend_cnt != LAST);
      end
      if (tok[LOAD]) obuf <= rd_word;
      rq_early <= |tok[PIPE-2:LOAD];
      rq_valid <= |tok[PIPE-1:LAT_HALF-1];
      rq_data  <= nxt_data;
    end
  end
endmodule

// File: rtl/qrw_port_sched.sv
module qrw_port_sched
  import qrw_pkg::*;
#(
  parameter int AW       = 4,
  parameter int LAT_HALF = 5
) (
  input  logic              clk2x,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              wr_req,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BEAT_W-1:0] wd_beat,
  input  logic [BE_W-1:0]   wd_be,
  output logic              k_next,
  output logic              gnt_rd,
  output logic              gnt_wr,
  output logic              gnt_idle,
  output logic              rq_early,
  output logic              rq_valid,
  output logic [BEAT_W-1:0] rq_data
);
  logic              ph;
  logic              rd_start, wr_start;
  logic              pend_active, cm_en;
  logic [AW-1:0]     pend_addr;
  logic [CNT_W-1:0]  pend_cnt;
  logic [WORD_W-1:0] pend_w, cm_data, mem_rdata;
  logic [MASK_W-1:0] pend_m, cm_mask;

  // ph = 0 means the coming edge is a true-clock rise.
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= ~ph;
  end
  assign k_next = ~ph;

  qrw_arbiter arb_i (
    .clk(clk2x), .rst_n(rst_n), .k_edge(k_next),
    .rd_req(rd_req), .wr_req(wr_req),
    .rd_start(rd_start), .wr_start(wr_start),
    .gnt_rd(gnt_rd), .gnt_wr(gnt_wr), .gnt_idle(gnt_idle)
  );

  qrw_wr_buffer #(.AW(AW)) wbuf_i (
    .clk(clk2x), .rst_n(rst_n), .start(wr_start), .start_addr(wr_addr),
    .beat(wd_beat), .be(wd_be),
    .active(pend_active), .addr(pend_addr), .cnt(pend_cnt),
    .bufw(pend_w), .bufm(pend_m),
    .cm_en(cm_en), .cm_data(cm_data), .cm_mask(cm_mask)
  );

  qrw_array #(.AW(AW)) mem_i (
    .clk(clk2x), .we(cm_en), .waddr(pend_addr), .wdata(cm_data), .wmask(cm_mask),
    .raddr(rd_addr), .rdata(mem_rdata)
  );

  qrw_rd_pipe #(.AW(AW), .LAT_HALF(LAT_HALF)) rpipe_i (
    .clk(clk2x), .rst_n(rst_n), .rd_start(rd_start), .rd_addr(rd_addr),
    .mem_rdata(mem_rdata),
    .pend_active(pend_active), .pend_addr(pend_addr), .pend_cnt(pend_cnt),
    .pend_w(pend_w), .pend_m(pend_m),
    .live_beat(wd_beat), .live_be(wd_be),
    .rq_early(rq_early), .rq_valid(rq_valid), .rq_data(rq_data)
  );
endmodule

// File: rtl/qrw_port_sched_chk.sv
module qrw_port_sched_chk #(
  parameter int LAT_HALF = 5
) (
  input logic clk2x,
  input logic rst_n,
  input logic k_next,
  input logic gnt_rd,
  input logic gnt_wr,
  input logic gnt_idle,
  input logic rq_early,
  input logic rq_valid
);
  // Marks, per edge, how long ago a read grant first became visible.
  logic [LAT_HALF:0] since_rd;
  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) since_rd <= '0;
    else        since_rd <= {since_rd[LAT_HALF-1:0], gnt_rd & ~k_next};
  end

  assert_grant_onehot_R2: assert property (@(posedge clk2x) disable iff (!rst_n)
    $countones({gnt_rd, gnt_wr, gnt_idle}) == 1);

  assert_grant_stable_R1: assert property (@(posedge clk2x) disable iff (!rst_n)
    !k_next |=> $stable({gnt_rd, gnt_wr, gnt_idle}));

  assert_no_read_twice_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    (k_next && gnt_rd) |=> !gnt_rd);

  assert_no_write_twice_R4: assert property (@(posedge clk2x) disable iff (!rst_n)
    (k_next && gnt_wr) |=> !gnt_wr);

  assert_early_flag_R9: assert property (@(posedge clk2x) disable iff (!rst_n)
    since_rd[LAT_HALF-2] |-> rq_early);

  assert_first_beat_R8: assert property (@(posedge clk2x) disable iff (!rst_n)
    since_rd[LAT_HALF-1] |-> rq_valid);
endmodule

bind qrw_port_sched qrw_port_sched_chk #(.LAT_HALF(LAT_HALF)) chk_i (
  .clk2x(clk2x), .rst_n(rst_n), .k_next(k_next),
  .gnt_rd(gnt_rd), .gnt_wr(gnt_wr), .gnt_idle(gnt_idle),
  .rq_early(rq_early), .rq_valid(rq_valid)
);

// File: tb/qrw_port_sched_tb_top.sv
`timescale 1ns/1ps
module qrw_port_sched_tb_top;
  localparam int AW = 4;
  localparam int NE = 16384;

  logic        clk2x = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0, wr_req = 1'b0;
  logic [AW-1:0] rd_addr = '0, wr_addr = '0;
  logic [17:0] wd_beat = '0;
  logic [1:0]  wd_be = '0;
  logic        k_next, gnt_rd, gnt_wr, gnt_idle, rq_early, rq_valid;
  logic [17:0] rq_data;

  always #2.5 clk2x = ~clk2x;

  qrw_port_sched #(.AW(AW), .LAT_HALF(5)) dut_i (
    .clk2x(clk2x), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
    .wr_req(wr_req), .wr_addr(wr_addr), .wd_beat(wd_beat), .wd_be(wd_be),
    .k_next(k_next), .gnt_rd(gnt_rd), .gnt_wr(gnt_wr), .gnt_idle(gnt_idle),
    .rq_early(rq_early), .rq_valid(rq_valid), .rq_data(rq_data)
  );

  int checks = 0, bad = 0, ec = 0, prev_g = 0;
  bit done = 1'b0;
  logic [71:0] ref_mem [16];
  logic [1:0]  exp_g [NE];
  bit          exp_q [NE];
  bit          exp_v [NE];
  logic [17:0] exp_d [NE];
  logic [17:0] nb_d [4];
  logic [1:0]  nb_m [4];
  int          nb_left = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s at edge %0d: act=%0h exp=%0h", req, what, ec, act, expv);
    end
  endtask

  function automatic logic [17:0] mrg(input logic [17:0] o, input logic [17:0] n,
                                      input logic [1:0] be);
    logic [17:0] r = o;
    if (be[0]) r[8:0]  = n[8:0];
    if (be[1]) r[17:9] = n[17:9];
    return r;
  endfunction

  task automatic check_edge();
    logic [2:0] g = {gnt_rd, gnt_wr, gnt_idle};
    logic [2:0] eg = (exp_g[ec] == 2'd1) ? 3'b100 : (exp_g[ec] == 2'd2) ? 3'b010 : 3'b001;
    chk(g == eg, "R1 R2 R3 R4 R5", "grant", 32'(g), 32'(eg));
    chk(rq_valid == exp_q[ec], "R8", "rq_valid", 32'(rq_valid), 32'(exp_q[ec]));
    chk(rq_early == exp_v[ec], "R9", "rq_early", 32'(rq_early), 32'(exp_v[ec]));
    if (exp_q[ec])
      chk(rq_data == exp_d[ec], "R6 R7 R8", "read beat", 32'(rq_data), 32'(exp_d[ec]));
  endtask

  // One true-clock cycle: the true-clock edge, then the complementary edge.
  task automatic kstep(input bit rs, input logic [AW-1:0] ra, input bit ws,
                       input logic [AW-1:0] wa, input bit full);
    chk(k_next == 1'b1, "R1", "phase at step start", 32'(k_next), 32'd1);
    for (int h = 0; h < 2; h++) begin
      int e = ec + 1;
      if (h == 0) begin
        rd_req = rs; rd_addr = ra; wr_req = ws; wr_addr = wa;
      end else begin
        rd_req = 1'($urandom); rd_addr = AW'($urandom);
        wr_req = 1'($urandom); wr_addr = AW'($urandom);
      end
      if (nb_left > 0) begin
        wd_beat = nb_d[4-nb_left]; wd_be = nb_m[4-nb_left]; nb_left--;
      end else begin
        wd_beat = 18'($urandom); wd_be = 2'($urandom);
      end
      if (h == 0) begin
        bit rok = rs && (prev_g != 1);
        bit wok = ws && (prev_g != 2);
        int g = rok ? 1 : (wok ? 2 : 0);
        exp_g[e] = 2'(g);
        prev_g = g;
        if (g == 2) begin
          for (int k = 0; k < 4; k++) begin
            nb_d[k] = 18'($urandom);
            nb_m[k] = full ? 2'b11 : 2'($urandom);
            ref_mem[wa][k*18 +: 18] = mrg(ref_mem[wa][k*18 +: 18], nb_d[k], nb_m[k]);
          end
          nb_left = 4;
        end else if (g == 1 && e + 9 < NE) begin
          for (int k = 0; k < 4; k++) begin
            exp_d[e+5+k] = ref_mem[ra][k*18 +: 18];
            exp_q[e+5+k] = 1'b1;
            exp_v[e+4+k] = 1'b1;
          end
        end
      end else begin
        exp_g[e] = exp_g[e-1];
      end
      @(posedge clk2x); ec++;
      @(negedge clk2x);
      check_edge();
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog R8: act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    for (int i = 0; i < NE; i++) begin
      exp_g[i] = 2'd0; exp_q[i] = 1'b0; exp_v[i] = 1'b0; exp_d[i] = '0;
    end
    for (int a = 0; a < 16; a++) ref_mem[a] = '0;
    repeat (3) @(negedge clk2x);
    // R10: reset state
    chk({gnt_rd, gnt_wr, gnt_idle} == 3'b001, "R10", "reset grant",
        32'({gnt_rd, gnt_wr, gnt_idle}), 32'd1);
    chk(rq_valid == 1'b0 && rq_early == 1'b0, "R10", "reset valids",
        32'({rq_valid, rq_early}), 32'd0);
    chk(k_next == 1'b1, "R10", "reset phase", 32'(k_next), 32'd1);
    rst_n = 1'b1;

    // Fill every address with full-enable writes, one every other rise.
    for (int a = 0; a < 16; a++) begin
      kstep(1'b0, '0, 1'b1, AW'(a), 1'b1);
      kstep(1'b0, '0, 1'b0, '0, 1'b1);
    end

    // R5 R3: both requests held from idle on one address, partial enables (R6 R7).
    kstep(1'b0, '0, 1'b0, '0, 1'b0);
    for (int i = 0; i < 10; i++) kstep(1'b1, 4'd5, 1'b1, 4'd5, 1'b0);
    kstep(1'b0, '0, 1'b0, '0, 1'b0);

    // R6: write then read of the same address on the next rise.
    kstep(1'b0, '0, 1'b1, 4'd2, 1'b0);
    kstep(1'b1, 4'd2, 1'b0, '0, 1'b0);
    kstep(1'b0, '0, 1'b0, '0, 1'b0);

    // R4: back-to-back reads, then back-to-back writes; the dropped write is read back.
    kstep(1'b1, 4'd3, 1'b0, '0, 1'b0);
    kstep(1'b1, 4'd4, 1'b0, '0, 1'b0);
    kstep(1'b0, '0, 1'b1, 4'd6, 1'b0);
    kstep(1'b0, '0, 1'b1, 4'd7, 1'b1);
    kstep(1'b0, '0, 1'b0, '0, 1'b0);
    kstep(1'b1, 4'd7, 1'b0, '0, 1'b0);
    kstep(1'b0, '0, 1'b0, '0, 1'b0);

    // Random traffic, mostly on four addresses to force collisions.
    for (int i = 0; i < 3000; i++) begin
      bit narrow = ($urandom % 4) != 0;
      logic [AW-1:0] ra = narrow ? AW'($urandom % 4) : AW'($urandom);
      logic [AW-1:0] wa = narrow ? AW'($urandom % 4) : AW'($urandom);
      kstep(1'(($urandom % 4) != 0), ra, 1'(($urandom % 4) != 0), wa, 1'b0);
    end
    for (int i = 0; i < 6; i++) kstep(1'b0, '0, 1'b0, '0, 1'b0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule